// File: doc/BRIEF.md
# Command-Driven SPI DMA Controller

This block is an SPI master that moves bytes between an SPI slave and system memory without processor help. Software sees three channels (receive, transmit and command), each with a start address, a byte count and a configuration word. All of them are reached through a small 32-bit register port.

A transfer does not begin when software programs a data channel. It begins when a command word, which software has placed in memory, names that channel. Enabling the command channel makes the block read one word from the command buffer. The top four bits of that word are the opcode. A receive opcode clocks bytes in from the slave and stores them in memory. A transmit opcode reads bytes from memory and shifts them out. Any other opcode is dropped. Each channel has its own one-cycle completion interrupt, and a busy flag covers the whole span from the command read to the end of the transfer.

The memory port serves both the command read and the byte transfers. It has a fixed latency of one cycle: the little-endian word starting at the requested address appears on `mem_rdata` in the cycle after `mem_req`. A byte read uses bits 7:0 of that word.

Top module: `spi_cmd_dma`

## Requirements
- R1: Each channel n (0 receive, 1 transmit, 2 command) has three registers at byte offset 16*n: a 32-bit address at +0, a byte count at +8'h4 of which only bits 19:0 are kept, and a configuration at +8'h8 of which only bits 0, 1, 2, 4 and 5 are kept. All other bits, and all unmapped offsets, read as zero.
- R2: A write to the command configuration with bit 4 set, made while no command is pending, issues exactly one memory read at command address + 8. The opcode is taken from bits 31:28 of the returned word. `irq_cmd` pulses for one cycle after every such read. A write with bit 4 clear reads nothing.
- R3: A write to the command configuration while a command is pending or running is ignored: no memory read and no `irq_cmd` pulse.
- R4: Opcode 4'h7 with receive enable set (receive configuration bit 4) starts a receive. It shifts out 8'h00 for each byte, stores the N returned bytes at receive address + i for i = 0..N-1, and then pulses `irq_rx` for one cycle.
- R5: Opcode 4'h6 with transmit enable set (transmit configuration bit 4) starts a transmit. It reads N bytes from transmit address + i in increasing order, shifts each byte out, and then pulses `irq_tx` for one cycle.
- R6: If the matching enable is clear when the opcode is fetched, the command stays pending until a write to that channel's configuration with bit 4 set starts it. A configuration write to a data channel whose opcode is not pending has no effect.
- R7: Any opcode other than 4'h6 or 4'h7 clears the pending command in the same cycle as its `irq_cmd` pulse, with no SPI activity.
- R8: The SPI bus runs in mode 0, MSB first. `sclk` idles low, each phase lasts one system clock (period of two clocks), `mosi` changes only while `sclk` is low, and `miso` is sampled on the rising edge.
- R9: `cs_n` goes low once before the first byte of a transfer and stays low across all its bytes. It returns high after the last byte, and `sclk` is low whenever `cs_n` is high.
- R10: `busy` is high from the command read until the cycle of the final interrupt (`irq_rx`/`irq_tx`, or `irq_cmd` for a dropped opcode). It falls only in that cycle.
- R11: A started transfer with a byte count of zero pulses its completion interrupt without asserting `cs_n` and without any data access to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| irq_rx | output | 1 | Receive completion pulse |
| irq_tx | output | 1 | Transmit completion pulse |
| irq_cmd | output | 1 | Command fetched pulse |
| busy | output | 1 | Command in progress |

## Verification
The hardest state to reach is a fetched command that is held pending because its data channel was disabled at fetch time. Only in that window can the ignore rule for a second command write, and the no-effect rule for a write to the wrong data channel, be seen. The stimulus clears the receive enable, fetches a receive opcode, and then checks that `busy` stays high with no chip select or memory traffic. While the command is parked, it writes the command configuration and the transmit configuration. It then releases the command by writing the receive configuration, and a scoreboard compares every shifted byte and every stored byte against the queued expectations.

// File: rtl/spicd_pkg.sv
package spicd_pkg;
   localparam int NCH       = 3;
   localparam int CH_RX     = 0;
   localparam int CH_TX     = 1;
   localparam int CH_CMD    = 2;
   localparam int CH_STRIDE = 16;
   localparam int OFF_ADDR  = 0;
   localparam int OFF_SIZE  = 4;
   localparam int OFF_CFG   = 8;
   localparam int CFG_EN_BIT = 4;
   localparam logic [5:0] CFG_KEEP = 6'h37;
   localparam int CMD_WORD_OFS = 8;

   typedef logic [3:0] opcode_t;
   localparam opcode_t OPC_SEND = 4'h6;
   localparam opcode_t OPC_RECV = 4'h7;
   localparam opcode_t OPC_NONE = 4'hF;

   typedef enum logic [3:0] {
      ST_IDLE, ST_FETCH, ST_FWAIT, ST_START, ST_LOAD,
      ST_TWAIT, ST_SHIFT, ST_WRITE, ST_DONE
   } seq_state_e;
endpackage

// File: rtl/spicd_regs.sv
module spicd_regs
   import spicd_pkg::*;
#(
   parameter int REG_AW = 7,
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 20
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [REG_AW-1:0]             reg_addr,
   input  logic [31:0]                   reg_wdata,
   output logic [31:0]                   reg_rdata,
   output logic [NCH-1:0][ADDR_W-1:0]    ch_addr,
   output logic [NCH-1:0][SIZE_W-1:0]    ch_size,
   output logic [NCH-1:0]                ch_en,
   output logic [NCH-1:0]                ch_go
);
   initial begin
      assert (REG_AW >= 6) else $error("REG_AW too small for the register window");
      assert (ADDR_W >= 1 && ADDR_W <= 32) else $error("ADDR_W out of range");
      assert (SIZE_W >= 1 && SIZE_W <= ADDR_W) else $error("SIZE_W out of range");
   end

   logic [ADDR_W-1:0] addr_q [NCH];
   logic [SIZE_W-1:0] size_q [NCH];
   logic [5:0]        cfg_q  [NCH];

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int BASE = c * CH_STRIDE;
      logic hit_a, hit_s, hit_c;
      assign hit_a = reg_wr && (reg_addr == REG_AW'(BASE + OFF_ADDR));
      assign hit_s = reg_wr && (reg_addr == REG_AW'(BASE + OFF_SIZE));
      assign hit_c = reg_wr && (reg_addr == REG_AW'(BASE + OFF_CFG));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_q[c] <= '0;
            size_q[c] <= '0;
            cfg_q[c]  <= '0;
         end else begin
            if (hit_a) addr_q[c] <= reg_wdata[ADDR_W-1:0];
            if (hit_s) size_q[c] <= reg_wdata[SIZE_W-1:0];
            if (hit_c) cfg_q[c]  <= reg_wdata[5:0] & CFG_KEEP;
         end
      end

      assign ch_addr[c] = addr_q[c];
      assign ch_size[c] = size_q[c];
      assign ch_en[c]   = cfg_q[c][CFG_EN_BIT];
      assign ch_go[c]   = hit_c && reg_wdata[CFG_EN_BIT];
   end

   always_comb begin
      reg_rdata = '0;
      for (int c = 0; c < NCH; c++) begin
         if (reg_addr == REG_AW'(c * CH_STRIDE + OFF_ADDR)) reg_rdata = 32'(addr_q[c]);
         if (reg_addr == REG_AW'(c * CH_STRIDE + OFF_SIZE)) reg_rdata = 32'(size_q[c]);
         if (reg_addr == REG_AW'(c * CH_STRIDE + OFF_CFG))  reg_rdata = 32'(cfg_q[c]);
      end
   end
endmodule

// File: rtl/spicd_shift.sv
module spicd_shift #(
   parameter int SCLK_HALF = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sclk,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx_byte
);
   initial begin
      assert (SCLK_HALF >= 1) else $error("SCLK_HALF must be at least 1");
   end

   logic       active;
   logic       tick;
   logic [2:0] bitn;
   logic [7:0] sr_tx;

   if (SCLK_HALF == 1) begin : g_fast
      assign tick = 1'b1;
   end else begin : g_div
      localparam int HW = $clog2(SCLK_HALF);
      logic [HW-1:0] hc;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                hc <= '0;
         else if (!active || start)                 hc <= '0;
         else if (hc == HW'(SCLK_HALF - 1))         hc <= '0;
         else                                       hc <= hc + 1'b1;
      end
      assign tick = (hc == HW'(SCLK_HALF - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         sclk    <= 1'b0;
         mosi    <= 1'b0;
         done    <= 1'b0;
         bitn    <= '0;
         sr_tx   <= '0;
         rx_byte <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active <= 1'b1;
            sclk   <= 1'b0;
            bitn   <= '0;
            sr_tx  <= tx_byte;
            mosi   <= tx_byte[7];
         end else if (active && tick) begin
            if (!sclk) begin
               sclk    <= 1'b1;
               rx_byte <= {rx_byte[6:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bitn == 3'd7) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  bitn  <= bitn + 1'b1;
                  sr_tx <= {sr_tx[6:0], 1'b0};
                  mosi  <= sr_tx[6];
               end
            end
         end
      end
   end
endmodule

// File: rtl/spicd_seq.sv
module spicd_seq
   import spicd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 20
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NCH-1:0][ADDR_W-1:0] ch_addr,
   input  logic [NCH-1:0][SIZE_W-1:0] ch_size,
   input  logic [NCH-1:0]             ch_en,
   input  logic [NCH-1:0]             ch_go,
   output logic                       mem_req,
   output logic                       mem_we,
   output logic [ADDR_W-1:0]          mem_addr,
   output logic [7:0]                 mem_wdata,
   input  logic [31:0]                mem_rdata,
   output logic                       sh_start,
   output logic [7:0]                 sh_byte,
   input  logic                       sh_done,
   input  logic [7:0]                 sh_rx,
   output logic                       cs_n,
   output logic                       busy,
   output logic                       irq_rx,
   output logic                       irq_tx,
   output logic                       irq_cmd
);
   seq_state_e        st;
   opcode_t           pend;
   logic [SIZE_W-1:0] idx;
   logic              is_tx;
   logic [SIZE_W-1:0] cur_size;
   logic              last;
   opcode_t           fetched;
   logic [27:0]       unused_rdata;

   assign is_tx    = (pend == OPC_SEND);
   assign cur_size = is_tx ? ch_size[CH_TX] : ch_size[CH_RX];
   assign last     = (SIZE_W'(idx + 1'b1) == cur_size);
   assign fetched  = mem_rdata[31:28];
   assign unused_rdata = mem_rdata[27:0];

   assign busy = (st != ST_IDLE) || (pend != OPC_NONE);
   assign cs_n = !(st == ST_LOAD || st == ST_TWAIT || st == ST_SHIFT || st == ST_WRITE);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      sh_start  = 1'b0;
      sh_byte   = '0;
      unique case (st)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = ch_addr[CH_CMD] + ADDR_W'(CMD_WORD_OFS);
         end
         ST_LOAD: begin
            if (is_tx) begin
               mem_req  = 1'b1;
               mem_addr = ch_addr[CH_TX] + ADDR_W'(idx);
            end else begin
               sh_start = 1'b1;
            end
         end
         ST_TWAIT: begin
            sh_start = 1'b1;
            sh_byte  = mem_rdata[7:0];
         end
         ST_WRITE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ch_addr[CH_RX] + ADDR_W'(idx);
            mem_wdata = sh_rx;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         pend    <= OPC_NONE;
         idx     <= '0;
         irq_rx  <= 1'b0;
         irq_tx  <= 1'b0;
         irq_cmd <= 1'b0;
      end else begin
         irq_rx  <= 1'b0;
         irq_tx  <= 1'b0;
         irq_cmd <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (ch_go[CH_CMD] && pend == OPC_NONE)     st <= ST_FETCH;
               else if (ch_go[CH_RX] && pend == OPC_RECV) st <= ST_START;
               else if (ch_go[CH_TX] && pend == OPC_SEND) st <= ST_START;
            end
            ST_FETCH: st <= ST_FWAIT;
            ST_FWAIT: begin
               irq_cmd <= 1'b1;
               if (fetched == OPC_RECV) begin
                  pend <= OPC_RECV;
                  st   <= ch_en[CH_RX] ? ST_START : ST_IDLE;
               end else if (fetched == OPC_SEND) begin
                  pend <= OPC_SEND;
                  st   <= ch_en[CH_TX] ? ST_START : ST_IDLE;
               end else begin
                  pend <= OPC_NONE;
                  st   <= ST_IDLE;
               end
            end
            ST_START: begin
               idx <= '0;
               st  <= (cur_size == '0) ? ST_DONE : ST_LOAD;
            end
            ST_LOAD:  st <= is_tx ? ST_TWAIT : ST_SHIFT;
            ST_TWAIT: st <= ST_SHIFT;
            ST_SHIFT: begin
               if (sh_done) begin
                  if (!is_tx)    st <= ST_WRITE;
                  else if (last) st <= ST_DONE;
                  else begin
                     idx <= idx + 1'b1;
                     st  <= ST_LOAD;
                  end
               end
            end
            ST_WRITE: begin
               if (last) st <= ST_DONE;
               else begin
                  idx <= idx + 1'b1;
                  st  <= ST_LOAD;
               end
            end
            ST_DONE: begin
               irq_rx <= !is_tx;
               irq_tx <= is_tx;
               pend   <= OPC_NONE;
               st     <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_cmd_dma.sv
module spi_cmd_dma
   import spicd_pkg::*;
#(
   parameter int REG_AW    = 7,
   parameter int ADDR_W    = 32,
   parameter int SIZE_W    = 20,
   parameter int SCLK_HALF = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              sclk,
   output logic              cs_n,
   output logic              mosi,
   input  logic              miso,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_cmd,
   output logic              busy
);
   logic [NCH-1:0][ADDR_W-1:0] ch_addr;
   logic [NCH-1:0][SIZE_W-1:0] ch_size;
   logic [NCH-1:0]             ch_en;
   logic [NCH-1:0]             ch_go;
   logic                       sh_start, sh_done;
   logic [7:0]                 sh_byte, sh_rx;

   spicd_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .ch_addr, .ch_size, .ch_en, .ch_go
   );

   spicd_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_seq (
      .clk, .rst_n, .ch_addr, .ch_size, .ch_en, .ch_go,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
      .sh_start, .sh_byte, .sh_done, .sh_rx,
      .cs_n, .busy, .irq_rx, .irq_tx, .irq_cmd
   );

   spicd_shift #(.SCLK_HALF(SCLK_HALF)) u_shift (
      .clk, .rst_n, .start(sh_start), .tx_byte(sh_byte), .miso,
      .sclk, .mosi, .done(sh_done), .rx_byte(sh_rx)
   );
endmodule

// File: rtl/spicd_checker.sv
module spicd_checker #(
   parameter int SCLK_HALF = 1
) (
   input logic clk,
   input logic rst_n,
   input logic sclk,
   input logic cs_n,
   input logic mosi,
   input logic busy,
   input logic irq_rx,
   input logic irq_tx,
   input logic irq_cmd,
   input logic mem_req,
   input logic mem_we
);
   assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));

   if (SCLK_HALF == 1) begin : g_rate
      assert_sclk_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
         sclk |=> !sclk);
   end

   assert_sclk_framed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   assert_frame_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

   assert_store_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !cs_n);

   assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |=> !irq_rx);

   assert_tx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |=> !irq_tx);

   assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cmd |=> !irq_cmd);

   assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (irq_rx || irq_tx || irq_cmd));

   assert_one_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_rx, irq_tx}));
endmodule

bind spi_cmd_dma spicd_checker #(.SCLK_HALF(SCLK_HALF)) u_chk (
   .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
   .busy(busy), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_cmd(irq_cmd),
   .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/test_spi_cmd_dma.sv
`timescale 1ns/1ps
module test_spi_cmd_dma;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [6:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        sclk, cs_n, mosi;
   logic        miso = 1'b0;
   logic        irq_rx, irq_tx, irq_cmd, busy;

   always #2 clk = ~clk;

   spi_cmd_dma i_spi_cmd_dma (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
      .sclk, .cs_n, .mosi, .miso, .irq_rx, .irq_tx, .irq_cmd, .busy
   );

   int n_chk = 0, n_fail = 0;
   int n_icmd = 0, n_irx = 0, n_itx = 0, n_csf = 0;
   bit finished = 0;
   logic prev_cs = 1'b1;

   logic [7:0]  exp_mosi[$];
   logic [39:0] exp_wr[$];
   logic [31:0] rd_log[$];
   logic [7:0]  slave_q[$];
   logic [7:0]  mem [0:255];

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // memory model: one cycle read latency, little-endian word
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else mem_rdata <= {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                            mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
      end
   end

   // monitor: counts and store scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_cmd) n_icmd++;
         if (irq_rx)  n_irx++;
         if (irq_tx)  n_itx++;
         if (prev_cs && !cs_n) n_csf++;
         prev_cs = cs_n;
         if (mem_req && !mem_we) rd_log.push_back(mem_addr);
         if (mem_req && mem_we) begin
            if (exp_wr.size() == 0) chk(0, "R4 unexpected store", {mem_addr, mem_wdata}, 0);
            else begin
               logic [39:0] e;
               e = exp_wr.pop_front();
               chk({mem_addr, mem_wdata} == e, "R4 stored byte", {mem_addr, mem_wdata}, e);
            end
         end
      end
   end

   // SPI slave model, mode 0
   int sbit = 0;
   logic [7:0] s_tx = '0, s_rx = '0;
   always @(negedge cs_n) begin
      sbit = 0;
      s_tx = (slave_q.size() != 0) ? slave_q.pop_front() : 8'h00;
      miso = s_tx[7];
   end
   always @(posedge sclk) begin
      if (!cs_n) begin
         s_rx = {s_rx[6:0], mosi};
         sbit++;
         if (sbit == 8) begin
            if (exp_mosi.size() == 0) chk(0, "R5 unexpected mosi byte", s_rx, 0);
            else begin
               logic [7:0] e;
               e = exp_mosi.pop_front();
               chk(s_rx == e, "R4/R5 mosi byte", s_rx, e);
            end
         end
      end
   end
   always @(negedge sclk) begin
      if (!cs_n) begin
         if (sbit == 8) begin
            sbit = 0;
            s_tx = (slave_q.size() != 0) ? slave_q.pop_front() : 8'h00;
            miso = s_tx[7];
         end else begin
            miso = s_tx[7 - sbit];
         end
      end
   end

   task automatic wr_reg(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_word(input logic [7:0] a, input logic [31:0] w);
      for (int i = 0; i < 4; i++) mem[a + 8'(i)] = w[8*i +: 8];
   endtask

   task automatic clear_counts();
      n_icmd = 0; n_irx = 0; n_itx = 0; n_csf = 0;
      rd_log.delete();
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk(cs_n == 1'b1 && sclk == 1'b0, "R9 reset cs_n/sclk", {cs_n, sclk}, 2'b10);
      chk(busy == 1'b0 && {irq_rx, irq_tx, irq_cmd} == 3'b0, "R10 reset busy/irqs", {busy, irq_rx, irq_tx, irq_cmd}, 0);
      chk(mem_req == 1'b0, "R2 reset no memory request", mem_req, 0);

      // R1 register map
      wr_reg(7'h20, 32'hDEAD_BEEF);
      rd_reg(7'h20, d); chk(d == 32'hDEAD_BEEF, "R1 address register", d, 32'hDEAD_BEEF);
      wr_reg(7'h14, 32'hFFFF_FFFF);
      rd_reg(7'h14, d); chk(d == 32'h000F_FFFF, "R1 size keeps bits 19:0", d, 32'h000F_FFFF);
      wr_reg(7'h08, 32'hFFFF_FFEF);
      rd_reg(7'h08, d); chk(d == 32'h0000_0027, "R1 config keeps bits 0,1,2,4,5", d, 32'h27);
      rd_reg(7'h0C, d); chk(d == 32'h0, "R1 unmapped offset reads zero", d, 0);

      // R2 negative: enable clear fetches nothing
      wr_reg(7'h08, 32'h0);
      wr_reg(7'h20, 32'h80);
      clear_counts();
      wr_reg(7'h28, 32'h0);
      repeat (6) @(negedge clk);
      chk(rd_log.size() == 0 && n_icmd == 0, "R2 no fetch without enable bit", rd_log.size(), 0);

      // R6 stray data channel enable while idle
      wr_reg(7'h14, 32'd2);
      wr_reg(7'h18, 32'h10);
      repeat (6) @(negedge clk);
      chk(busy == 0 && n_csf == 0 && rd_log.size() == 0, "R6 data enable without pending command", {busy, n_csf}, 0);

      // R5 transmit of three bytes
      mem[8'h40] = 8'hA5; mem[8'h41] = 8'h3C; mem[8'h42] = 8'h01;
      wr_reg(7'h10, 32'h40);
      wr_reg(7'h14, 32'd3);
      put_word(8'h88, 32'h6000_0000);
      exp_mosi.push_back(8'hA5); exp_mosi.push_back(8'h3C); exp_mosi.push_back(8'h01);
      clear_counts();
      wr_reg(7'h28, 32'h10);
      @(negedge clk);
      chk(busy == 1'b1, "R10 busy after command read", busy, 1);
      wait_idle();
      chk(n_icmd == 1, "R2 one irq_cmd per fetch", n_icmd, 1);
      chk(n_itx == 1 && n_irx == 0, "R5 irq_tx pulses once", {n_itx, n_irx}, {32'd1, 32'd0});
      chk(rd_log.size() == 4 && rd_log[0] == 32'h88, "R2 fetch at command address + 8", rd_log.size() > 0 ? rd_log[0] : 0, 32'h88);
      chk(rd_log.size() == 4 && rd_log[1] == 32'h40 && rd_log[3] == 32'h42, "R5 byte reads in order",
          rd_log.size() == 4 ? {rd_log[1], rd_log[3]} : 0, {32'h40, 32'h42});
      chk(exp_mosi.size() == 0, "R5 all bytes shifted", exp_mosi.size(), 0);
      chk(n_csf == 1 && cs_n == 1'b1, "R9 single frame, released after", {n_csf, cs_n}, {32'd1, 1'b1});

      // R4 receive of four bytes, low opcode bits nonzero
      wr_reg(7'h00, 32'h20);
      wr_reg(7'h04, 32'd4);
      wr_reg(7'h08, 32'h10);
      put_word(8'h88, 32'h7123_4567);
      slave_q.push_back(8'h81); slave_q.push_back(8'h7E);
      slave_q.push_back(8'hFF); slave_q.push_back(8'h00);
      for (int i = 0; i < 4; i++) exp_mosi.push_back(8'h00);
      exp_wr.push_back({32'h20, 8'h81}); exp_wr.push_back({32'h21, 8'h7E});
      exp_wr.push_back({32'h22, 8'hFF}); exp_wr.push_back({32'h23, 8'h00});
      clear_counts();
      wr_reg(7'h28, 32'h10);
      wait_idle();
      chk(n_irx == 1 && n_itx == 0, "R4 irq_rx pulses once", {n_irx, n_itx}, {32'd1, 32'd0});
      chk(exp_wr.size() == 0 && exp_mosi.size() == 0, "R4 all bytes stored", exp_wr.size(), 0);
      chk({mem[8'h20], mem[8'h21], mem[8'h22], mem[8'h23]} == 32'h817EFF00, "R4 memory contents",
          {mem[8'h20], mem[8'h21], mem[8'h22], mem[8'h23]}, 32'h817EFF00);
      chk(n_csf == 1, "R9 one frame for the receive", n_csf, 1);

      // R6 deferred start, R3 ignored command write
      wr_reg(7'h08, 32'h0);
      wr_reg(7'h04, 32'd2);
      put_word(8'h88, 32'h7000_0000);
      clear_counts();
      wr_reg(7'h28, 32'h10);
      repeat (10) @(negedge clk);
      chk(busy == 1 && n_csf == 0 && n_icmd == 1, "R6 command parked while disabled", {busy, n_csf, n_icmd}, {1'b1, 32'd0, 32'd1});
      rd_log.delete();
      wr_reg(7'h28, 32'h10);
      repeat (6) @(negedge clk);
      chk(rd_log.size() == 0 && n_icmd == 1, "R3 command write ignored while pending", {rd_log.size(), n_icmd}, {32'd0, 32'd1});
      wr_reg(7'h18, 32'h10);
      repeat (6) @(negedge clk);
      chk(n_csf == 0 && n_itx == 0 && busy == 1, "R6 wrong channel enable has no effect", {n_csf, n_itx}, 0);
      slave_q.push_back(8'h5A); slave_q.push_back(8'hC3);
      exp_mosi.push_back(8'h00); exp_mosi.push_back(8'h00);
      exp_wr.push_back({32'h20, 8'h5A}); exp_wr.push_back({32'h21, 8'hC3});
      wr_reg(7'h08, 32'h10);
      wait_idle();
      chk(n_irx == 1 && exp_wr.size() == 0 && busy == 0, "R6 receive enable releases the command", {n_irx, exp_wr.size()}, {32'd1, 32'd0});

      // R7 unsupported opcodes
      put_word(8'h88, 32'h3000_0000);
      clear_counts();
      wr_reg(7'h28, 32'h10);
      wait_idle();
      chk(n_icmd == 1 && n_csf == 0 && n_irx + n_itx == 0 && busy == 0, "R7 opcode 3 dropped", {n_icmd, n_csf}, {32'd1, 32'd0});
      put_word(8'h88, 32'hB000_0000);
      clear_counts();
      wr_reg(7'h28, 32'h10);
      wait_idle();
      chk(n_icmd == 1 && n_csf == 0 && n_irx + n_itx == 0 && busy == 0, "R7 opcode B dropped", {n_icmd, n_csf}, {32'd1, 32'd0});

      // R11 zero-length transmit
      wr_reg(7'h14, 32'd0);
      put_word(8'h88, 32'h6000_0000);
      clear_counts();
      wr_reg(7'h28, 32'h10);
      wait_idle();
      chk(n_itx == 1 && n_csf == 0 && rd_log.size() == 1, "R11 zero count completes without frame",
          {n_itx, n_csf, rd_log.size()}, {32'd1, 32'd0, 32'd1});

      // R8 bit order: single transmit byte 0x01 seen via scoreboard
      mem[8'h40] = 8'h01;
      wr_reg(7'h14, 32'd1);
      exp_mosi.push_back(8'h01);
      clear_counts();
      wr_reg(7'h28, 32'h10);
      wait_idle();
      chk(exp_mosi.size() == 0 && n_itx == 1, "R8 MSB-first byte 0x01", exp_mosi.size(), 0);

      finish_run();
   end
endmodule